// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory, one 4-byte entry per level, with 10-bit indices and 4 KiB pages. A request carries the virtual address, the access kind (fetch, load or store), whether the access comes from user mode, the root page number of the table, and two status bits. One bit lets supervisor code touch user pages. The other lets loads read execute-only pages.

The walker reads entries through a request/response memory port. The request side uses a valid/ready handshake. The response side is a one-cycle data-valid pulse. When a successful access must set the accessed bit or the dirty bit, the walker writes the updated entry back through the same port before it returns the result. It returns either a fault or the physical address with read, write and execute permissions. Leaves found at the first level map 4 MiB superpages.

Entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 6 accessed, bit 7 dirty, bits [31:10] page number. Access kind encoding: 0 fetch, 1 load, 2 store, 3 reserved (always faults).

Top module: `pt_walk2`

## Requirements
- R1: The first entry is read at {root, vaddr[31:22], 2'b00}. The second entry is read at {next page number, vaddr[21:12], 2'b00}.
- R2: An entry with bit 0 (valid) clear ends the walk with a fault.
- R3: A valid entry whose bits 3:1 are all zero points to the next table. At the first level the walk descends using the entry's page number. At the second level such an entry faults.
- R4: A leaf with bit 2 (write) set and bit 1 (read) clear faults.
- R5: A page with bit 4 (user) set faults for a non-user access unless the supervisor-user bit is set. A non-user fetch from such a page always faults.
- R6: A page with bit 4 clear faults for a user access.
- R7: A first-level leaf whose page-number bits [9:0] are nonzero faults.
- R8: A load needs read, or execute when the make-readable bit is set. A store needs write. A fetch needs execute. Kind 3 faults.
- R9: On success the entry is written back with bit 6 set, and bit 7 also set for stores. The write happens only when the entry changes, and it is accepted before the result appears. A fault writes nothing.
- R10: A second-level leaf gives {page number, vaddr[11:0]}. A first-level leaf gives {page number[21:10], vaddr[21:0]}.
- R11: Reported read = read bit or (execute bit and make-readable). Reported execute = execute bit. Reported write = write bit and (store or bit 7 already set). A fault reports address 0 and no permissions.
- R12: req_ready is high only when the walker is idle. A memory request stays stable until it is accepted. Each accepted request produces exactly one single-cycle resp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | Access from user mode |
| req_root | input | 22 | Root table page number |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Execute-only pages readable by loads |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 34 | Entry address |
| mem_req_we | output | 1 | Request is an entry write-back |
| mem_req_wdata | output | 32 | Updated entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_pa | output | 34 | Physical address |
| resp_r | output | 1 | Read permitted |
| resp_w | output | 1 | Write permitted |
| resp_x | output | 1 | Execute permitted |

## Verification
When a leaf entry arrives, the walker does two things in the same cycle. It judges permissions and builds the physical address, and it decides whether a write-back is needed. Stores to clean pages and loads to pages with the accessed bit clear provoke both at once. The memory port stalls in a pseudo-random pattern while this happens. A behavioural reference model predicts the ordered list of memory transactions and the final result for every walk. The bench compares each accepted transaction and each result against that prediction. It also requires every predicted transaction, including the write-back, to have been seen before the result appears.

// File: rtl/pt_walk2.sv
module pt_walk2 #(
  parameter int PPN_W = 22,
  parameter int IDX_W = 10,
  parameter int OFS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2*IDX_W+OFS_W-1:0] req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   req_user,
  input  logic [PPN_W-1:0]       req_root,
  input  logic                   req_sum,
  input  logic                   req_mxr,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PPN_W+OFS_W-1:0] mem_req_addr,
  output logic                   mem_req_we,
  output logic [PPN_W+9:0]       mem_req_wdata,
  input  logic                   mem_rsp_valid,
  input  logic [PPN_W+9:0]       mem_rsp_data,
  output logic                   resp_valid,
  output logic                   resp_fault,
  output logic [PPN_W+OFS_W-1:0] resp_pa,
  output logic                   resp_r,
  output logic                   resp_w,
  output logic                   resp_x
);
  localparam int VA_W  = 2*IDX_W + OFS_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int PTE_W = PPN_W + 10;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_DONE} state_t;
  state_t state;

  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic             user_q, sum_q, mxr_q, lvl;
  logic [PPN_W-1:0] base_q;
  logic [PTE_W-1:0] wdata_q;

  wire [IDX_W-1:0] cur_idx = lvl ? va_q[OFS_W+IDX_W-1:OFS_W] : va_q[VA_W-1:VA_W-IDX_W];

  assign req_ready     = state == S_IDLE;
  assign mem_req_valid = state == S_RD || state == S_WB;
  assign mem_req_we    = state == S_WB;
  assign mem_req_addr  = {base_q, cur_idx, 2'b00};
  assign mem_req_wdata = wdata_q;
  assign resp_valid    = state == S_DONE;

  wire [PTE_W-1:0] e = mem_rsp_data;
  wire [PPN_W-1:0] eppn = e[PTE_W-1:10];
  wire ev = e[0], er = e[1], ew = e[2], ex = e[3], eu = e[4], ed = e[7];

  wire is_fetch = kind_q == 2'd0;
  wire is_load  = kind_q == 2'd1;
  wire is_store = kind_q == 2'd2;

  wire rd_ok   = er | (ex & mxr_q);
  wire perm_ok = (is_fetch & ex) | (is_load & rd_ok) | (is_store & ew);
  wire u_bad   = eu ? (!user_q && (!sum_q || is_fetch)) : user_q;
  wire mis     = !lvl && (eppn[IDX_W-1:0] != '0);
  wire is_ptr  = ev & ~er & ~ew & ~ex;
  wire leaf_bad = !ev | (ew & !er) | u_bad | mis | !perm_ok;

  wire [PTE_W-1:0] upd = e | {{(PTE_W-8){1'b0}}, is_store, 1'b1, 6'b0};
  wire [PA_W-1:0]  leaf_pa = lvl ? {eppn, va_q[OFS_W-1:0]}
                                 : {eppn[PPN_W-1:IDX_W], va_q[OFS_W+IDX_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      va_q       <= '0;
      kind_q     <= '0;
      user_q     <= 1'b0;
      sum_q      <= 1'b0;
      mxr_q      <= 1'b0;
      lvl        <= 1'b0;
      base_q     <= '0;
      wdata_q    <= '0;
      resp_fault <= 1'b0;
      resp_pa    <= '0;
      resp_r     <= 1'b0;
      resp_w     <= 1'b0;
      resp_x     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q       <= req_vaddr;
          kind_q     <= req_kind;
          user_q     <= req_user;
          sum_q      <= req_sum;
          mxr_q      <= req_mxr;
          base_q     <= req_root;
          lvl        <= 1'b0;
          resp_fault <= 1'b0;
          resp_pa    <= '0;
          resp_r     <= 1'b0;
          resp_w     <= 1'b0;
          resp_x     <= 1'b0;
          state      <= S_RD;
        end
        S_RD: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (is_ptr && !lvl) begin
            base_q <= eppn;
            lvl    <= 1'b1;
            state  <= S_RD;
          end else if (is_ptr || leaf_bad) begin
            resp_fault <= 1'b1;
            state      <= S_DONE;
          end else begin
            resp_pa <= leaf_pa;
            resp_r  <= rd_ok;
            resp_x  <= ex;
            resp_w  <= ew & (is_store | ed);
            wdata_q <= upd;
            state   <= (upd != e) ? S_WB : S_DONE;
          end
        end
        S_WB: if (mem_req_ready) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walk2_checker.sv
module pt_walk2_checker #(
  parameter int PPN_W = 22,
  parameter int OFS_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_ready,
  input logic                   mem_req_valid,
  input logic                   mem_req_ready,
  input logic [PPN_W+OFS_W-1:0] mem_req_addr,
  input logic                   mem_req_we,
  input logic [PPN_W+9:0]       mem_req_wdata,
  input logic                   resp_valid,
  input logic                   resp_fault,
  input logic [PPN_W+OFS_W-1:0] resp_pa,
  input logic                   resp_r,
  input logic                   resp_w,
  input logic                   resp_x
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R12
  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready && !mem_req_valid); // R12
  AST_WB_MARKS_A: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[6] && mem_req_wdata[0] && (mem_req_wdata[1] || mem_req_wdata[3])); // R9
  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> !resp_r && !resp_w && !resp_x && resp_pa == '0); // R11
  AST_W_HAS_R: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_w |-> resp_r); // R4
endmodule

bind pt_walk2 pt_walk2_checker #(.PPN_W(PPN_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
  .mem_req_wdata(mem_req_wdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
  .resp_pa(resp_pa), .resp_r(resp_r), .resp_w(resp_w), .resp_x(resp_x));

// File: tb/pt_walk2_test.sv
module pt_walk2_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_user = 0, req_sum = 0, req_mxr = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic [21:0] req_root = 22'h00100;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        req_ready, mem_req_valid, mem_req_we, resp_valid, resp_fault, resp_r, resp_w, resp_x;
  logic [33:0] mem_req_addr, resp_pa;
  logic [31:0] mem_req_wdata;

  pt_walk2 uut (.*);

  int tests = 0, fails = 0;
  logic [31:0] mem [logic [33:0]];
  logic [33:0] ex_addr [$];
  logic        ex_we [$];
  logic [31:0] ex_wd [$];
  logic        ex_fault, ex_r, ex_w, ex_x, got_resp;
  logic [33:0] ex_pa;
  string       cur_tag;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [33:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind, input logic usr, sum, mxr);
    logic [21:0] base = req_root;
    logic [31:0] e, upd;
    logic [33:0] a;
    logic rok, pok, ubad, stop = 0;
    ex_fault = 1; ex_pa = 0; ex_r = 0; ex_w = 0; ex_x = 0;
    for (int lvl = 0; lvl < 2 && !stop; lvl++) begin
      a = {base, (lvl == 0) ? va[31:22] : va[21:12], 2'b00};
      ex_addr.push_back(a); ex_we.push_back(0); ex_wd.push_back(0);
      e = rd(a);
      if (!e[0]) stop = 1;
      else if (e[3:1] == 0) begin
        if (lvl == 1) stop = 1;
        base = e[31:10];
      end else begin
        stop = 1;
        rok = e[1] || (e[3] && mxr);
        pok = (kind == 0) ? e[3] : (kind == 1) ? rok : (kind == 2) ? e[2] : 1'b0;
        ubad = e[4] ? (!usr && (!sum || kind == 0)) : usr;
        if (!(e[2] && !e[1]) && !ubad && !(lvl == 0 && e[19:10] != 0) && pok) begin
          ex_fault = 0;
          ex_r = rok; ex_x = e[3]; ex_w = e[2] && (kind == 2 || e[7]);
          ex_pa = (lvl == 1) ? {e[31:10], va[11:0]} : {e[31:20], va[21:0]};
          upd = e | 32'h40 | ((kind == 2) ? 32'h80 : 32'h0);
          if (upd != e) begin
            ex_addr.push_back(a); ex_we.push_back(1); ex_wd.push_back(upd);
          end
        end
      end
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input logic [1:0] kind,
                      input logic usr, sum, mxr);
    int n = 0;
    cur_tag = tag;
    ref_walk(va, kind, usr, sum, mxr);
    got_resp = 0;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = usr; req_sum = sum; req_mxr = mxr;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!got_resp && n < 400) begin @(negedge clk); n++; end
    if (!got_resp) chk(0, {tag, " watchdog"}, 0, 1);
    @(negedge clk);
  endtask

  initial begin : responder
    logic [7:0] lfsr = 8'h5a;
    int rcnt = 0;
    logic [31:0] rdat = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = rdat; end
      end
      if (rst_n && resp_valid) begin
        got_resp = 1;
        chk(ex_addr.size() == 0, {cur_tag, " R9 pending transactions at result"}, ex_addr.size(), 0);
        chk(resp_fault == ex_fault, {cur_tag, " fault"}, resp_fault, ex_fault);
        chk(resp_pa == ex_pa, {cur_tag, " R10 pa"}, resp_pa, ex_pa);
        chk({resp_r, resp_w, resp_x} == {ex_r, ex_w, ex_x}, {cur_tag, " R11 rwx"},
            {resp_r, resp_w, resp_x}, {ex_r, ex_w, ex_x});
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[1];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (ex_addr.size() == 0) chk(0, {cur_tag, " R1 unexpected memory request"}, mem_req_addr, 0);
        else begin
          chk(mem_req_addr == ex_addr[0] && mem_req_we == ex_we[0],
              {cur_tag, " R1 request address/kind"}, {mem_req_we, mem_req_addr}, {ex_we[0], ex_addr[0]});
          if (ex_we[0]) chk(mem_req_wdata == ex_wd[0], {cur_tag, " R9 write-back data"}, mem_req_wdata, ex_wd[0]);
          void'(ex_addr.pop_front()); void'(ex_we.pop_front()); void'(ex_wd.pop_front());
        end
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        else begin rdat = rd(mem_req_addr); rcnt = 1 + int'(lfsr[3:2]); end
      end
    end
  end

  localparam logic [33:0] L0 = 34'h100000, L1 = 34'h200000;
  initial begin
    mem[L0 + 1*4] = pte(22'h00200, 8'h01);
    mem[L0 + 8*4] = pte(22'h00400, 8'h4B);
    mem[L0 + 9*4] = pte(22'h00401, 8'h4B);
    mem[L1 + 3*4]  = pte(22'h12345, 8'hC7);
    mem[L1 + 4*4]  = pte(22'h00ABC, 8'h07);
    mem[L1 + 5*4]  = pte(22'h00777, 8'h47);
    mem[L1 + 6*4]  = pte(22'h00300, 8'h01);
    mem[L1 + 7*4]  = pte(22'h00301, 8'h45);
    mem[L1 + 8*4]  = pte(22'h00302, 8'h4D);
    mem[L1 + 9*4]  = pte(22'h00303, 8'h5B);
    mem[L1 + 10*4] = pte(22'h00304, 8'h43);
    mem[L1 + 11*4] = pte(22'h00305, 8'h49);
    mem[L1 + 12*4] = pte(22'h00306, 8'h43);
    mem[L1 + 13*4] = pte(22'h00307, 8'h46);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R12 reset state",
        {req_ready, resp_valid, mem_req_valid}, 3'b100);
    walk("R1 R10 R11 dirty load",  {10'd1, 10'd3, 12'h123}, 2'd1, 0, 0, 0);
    walk("R9 store clean page",    {10'd1, 10'd4, 12'h010}, 2'd2, 0, 0, 0);
    walk("R9 R11 load no D",       {10'd1, 10'd5, 12'h020}, 2'd1, 0, 0, 0);
    walk("R2 invalid level 2",     {10'd1, 10'd13, 12'h0},  2'd1, 0, 0, 0);
    walk("R2 invalid level 1",     {10'd2, 10'd0, 12'h0},   2'd1, 0, 0, 0);
    walk("R3 pointer at level 2",  {10'd1, 10'd6, 12'h0},   2'd1, 0, 0, 0);
    walk("R4 write-only",          {10'd1, 10'd7, 12'h0},   2'd2, 0, 0, 0);
    walk("R4 write+exec",          {10'd1, 10'd8, 12'h0},   2'd0, 0, 0, 0);
    walk("R5 user page sum=0",     {10'd1, 10'd9, 12'h0},   2'd1, 0, 0, 0);
    walk("R5 user page sum=1",     {10'd1, 10'd9, 12'h4},   2'd1, 0, 1, 0);
    walk("R5 fetch user page",     {10'd1, 10'd9, 12'h8},   2'd0, 0, 1, 0);
    walk("R6 user on sup page",    {10'd1, 10'd10, 12'h0},  2'd1, 1, 0, 0);
    walk("R10 superpage fetch",    {10'd8, 10'h155, 12'hABC}, 2'd0, 0, 0, 0);
    walk("R7 misaligned super",    {10'd9, 10'h155, 12'h0}, 2'd1, 0, 0, 0);
    walk("R8 exec-only load",      {10'd1, 10'd11, 12'h0},  2'd1, 0, 0, 0);
    walk("R8 exec-only load mxr",  {10'd1, 10'd11, 12'h0},  2'd1, 0, 0, 1);
    walk("R8 store read-only",     {10'd1, 10'd12, 12'h0},  2'd2, 0, 0, 0);
    walk("R8 fetch no exec",       {10'd1, 10'd12, 12'h0},  2'd0, 0, 0, 0);
    walk("R8 reserved kind",       {10'd1, 10'd3, 12'h0},   2'd3, 0, 0, 0);
    walk("R9 store now dirty",     {10'd1, 10'd4, 12'h010}, 2'd2, 0, 0, 0);
    chk(mem[L1 + 4*4] == pte(22'h00ABC, 8'hC7), "R9 entry in memory", mem[L1 + 4*4], pte(22'h00ABC, 8'hC7));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule